// File: doc/BRIEF.md
# Stop-Mode Wake Controller

This block governs how a small microcontroller leaves its low-power states. It holds the power control byte in which software sets the idle and power-down bits, and it watches four external interrupt pins, a reset pin and two general-purpose ports for wake events. While stopped it drops the oscillator enable. When a valid wake event arrives it raises the oscillator enable again and keeps the CPU clock gated. Release then comes from one of two sources: a warm-up counter that reaches full count, or a rising edge on the interrupt pin that caused the wake.

On release the block reports the reason. A one-cycle pulse on one interrupt line means an interrupt service should start. A one-cycle resume pulse means a general-purpose pin caused the wake and execution continues with no interrupt. A reset-pin wake raises neither pulse and holds the core in reset for as long as the pin stays high. Each pin passes through a two-flop synchroniser on the oscillator clock before its edges are detected. The warm-up counter is WARM_W bits wide and lasts 2^WARM_W cycles.

Top module: `pwk_top`

## Requirements
- R1: After power-on reset, ctl_q reads 0x10, osc_en and cpu_clk_en are 1, and wake_irq, wake_resume and core_rst are 0.
- R2: Writing ctl_q with bit 1 set stops the block. osc_en and cpu_clk_en are 0 from the second clock edge after the write edge, and they stay 0 until a wake event.
- R3: When ext_release is 0, a falling edge on an interrupt pin whose int_en bit is set wakes a stopped block. osc_en returns, and cpu_clk_en rises 3 + 2^WARM_W clock edges after the pin changes. In that same cycle wake_irq pulses the bit of that interrupt (bit 0 is port_b[2], bit 1 is port_b[3], bit 2 is xint_pin[0], bit 3 is xint_pin[1]), and ctl_q bit 1 reads 0.
- R4: When ext_release is 1, an interrupt wake sets osc_en to 1 but keeps cpu_clk_en at 0, however long it lasts, until a rising edge on the same pin. cpu_clk_en and that pin's wake_irq bit rise 3 edges after that rising edge.
- R5: A rising edge on rst_pin while stopped wakes the block through the same warm-up count, with no wake_irq and no wake_resume. core_rst follows the synchronised rst_pin level.
- R6: A falling edge on an enabled port pin wakes a stopped block. wake_en_a bits 0-7 enable port_a, and wake_en_b bits 0-5 and 7 enable port_b. port_b bit 6 never wakes the block. Release comes after the warm-up count with a wake_resume pulse and wake_irq equal to 0.
- R7: port_b bits 2 and 3 wake through wake_en_b even when int_en bits 0 and 1 are clear. With the interrupt enabled, the same edge yields a wake_irq pulse and no resume, whether or not wake_en_b is set.
- R8: xint_pin edges wake the block only when int_en bit 2 or 3 is set. wake_en bits have no effect on these pins.
- R9: Pin edges seen while the block is running (not stopped, not idle) produce no wake_irq and no wake_resume, and they leave both clocks running.
- R10: While the synchronised rst_pin is high, ctl_q clears every bit except bit 4, which keeps its value. Writes while the CPU clock runs store all eight bits.
- R11: Setting ctl_q bit 0 (idle) gates cpu_clk_en while osc_en stays 1. An enabled interrupt falling edge clears bit 0, and that interrupt's wake_irq pulses 3 edges after the pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | External reset pin, active high |
| wr_en | input | 1 | Control byte write strobe (accepted only while cpu_clk_en is 1) |
| wr_data | input | 8 | Control byte write data |
| ctl_q | output | 8 | Control byte: bit 0 idle, bit 1 stop, bits 3:2 flags, bit 4 power-on flag |
| ext_release | input | 1 | 1 selects release on a rising edge of the waking interrupt pin |
| int_en | input | 4 | Interrupt enables for the four external interrupts |
| xint_pin | input | 2 | Pins of interrupts 2 and 3 |
| port_a | input | 8 | General-purpose port A pins |
| port_b | input | 8 | General-purpose port B pins; bits 2 and 3 carry interrupts 0 and 1 |
| wake_en_a | input | 8 | Per-pin wake enables of port A |
| wake_en_b | input | 8 | Per-pin wake enables of port B |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| core_rst | output | 1 | Synchronised reset level to the core |
| wake_irq | output | 4 | One-cycle interrupt request on release |
| wake_resume | output | 1 | One-cycle pulse on release after a port-pin wake |

## Verification
The assertions take for granted that each pin level is held for at least three oscillator cycles, so that the synchroniser sees every edge. They also assume that control writes arrive only while the CPU clock runs and that ext_release is steady through a wake. The stimulus changes pins only on falling clock edges and waits several cycles between changes. It never touches ext_release between the stop write and the release, and it recovers any deliberately failed wake with a reset-pin pulse before the next pattern.

// File: rtl/pwk_pkg.sv
package pwk_pkg;

  localparam int N_XINT  = 4;
  localparam int IDL_BIT = 0;
  localparam int PD_BIT  = 1;
  localparam int POF_BIT = 4;
  localparam logic [7:0] CTL_POR = 8'h10;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WARM = 2'd2,
    ST_HOLD = 2'd3
  } pwk_state_e;

  typedef enum logic [1:0] {
    SRC_INT  = 2'd0,
    SRC_GPIO = 2'd1,
    SRC_RST  = 2'd2
  } pwk_src_e;

  // Length of the warm-up window in oscillator cycles.
  function automatic int unsigned warm_cycles(input int unsigned w);
    return 32'd1 << w;
  endfunction

  // Lowest set bit wins among simultaneous interrupt edges.
  function automatic logic [1:0] low_index(input logic [N_XINT-1:0] v);
    logic [1:0] r;
    r = 2'd0;
    for (int i = N_XINT - 1; i >= 0; i--) begin
      if (v[i]) r = 2'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/pwk_sync.sv
module pwk_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] now,
  output logic [W-1:0] prev
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      s1   <= INIT;
      now  <= INIT;
      prev <= INIT;
    end else begin
      s1   <= d;
      now  <= s1;
      prev <= now;
    end
  end
endmodule

// File: rtl/pwk_ctl_reg.sv
module pwk_ctl_reg
  import pwk_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       soft_rst,
  input  logic       wr_ok,
  input  logic [7:0] wr_data,
  input  logic       pd_clr,
  input  logic       idl_clr,
  output logic [7:0] ctl
);
  localparam logic [7:0] POF_MASK = 8'(1 << POF_BIT);

  logic [7:0] ctl_d;

  always_comb begin
    ctl_d = ctl;
    if (soft_rst) begin
      ctl_d = ctl & POF_MASK;
    end else begin
      if (wr_ok)   ctl_d = wr_data;
      if (pd_clr)  ctl_d[PD_BIT]  = 1'b0;
      if (idl_clr) ctl_d[IDL_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) ctl <= CTL_POR;
    else        ctl <= ctl_d;
  end

  // R10: a reset level keeps the power-on flag and clears the rest
  a_r10_rst_keeps_pof: assert property (@(posedge clk) disable iff (!por_n)
    soft_rst |=> (ctl[POF_BIT] == $past(ctl[POF_BIT])) && ((ctl & ~POF_MASK) == 8'h00));

endmodule

// File: rtl/pwk_wake_fsm.sv
module pwk_wake_fsm
  import pwk_pkg::*;
#(
  parameter int WARM_W = 10
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              pd_bit,
  input  logic              idl_bit,
  input  logic              ext_release,
  input  logic              rst_rise,
  input  logic [N_XINT-1:0] int_fall,
  input  logic [N_XINT-1:0] int_rise,
  input  logic              gpio_wake,
  output pwk_state_e        state_q,
  output logic              pd_clr,
  output logic              idl_clr,
  output logic [N_XINT-1:0] wake_irq,
  output logic              wake_resume
);
  localparam logic [WARM_W-1:0] CNT_FULL = WARM_W'(warm_cycles(WARM_W) - 1);

  pwk_state_e        state_d;
  pwk_src_e          src_q, src_d;
  logic [1:0]        idx_q, idx_d;
  logic [WARM_W-1:0] cnt_q, cnt_d;
  logic [N_XINT-1:0] irq_d;
  logic              res_d;

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    pd_clr  = 1'b0;
    idl_clr = 1'b0;
    irq_d   = '0;
    res_d   = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (pd_bit) begin
          state_d = ST_STOP;
        end else if (idl_bit && (|int_fall)) begin
          idl_clr = 1'b1;
          irq_d[low_index(int_fall)] = 1'b1;
        end
      end
      ST_STOP: begin
        if (rst_rise) begin
          src_d   = SRC_RST;
          state_d = ST_WARM;
          cnt_d   = '0;
          pd_clr  = 1'b1;
        end else if (|int_fall) begin
          src_d   = SRC_INT;
          idx_d   = low_index(int_fall);
          state_d = ext_release ? ST_HOLD : ST_WARM;
          cnt_d   = '0;
          pd_clr  = 1'b1;
        end else if (gpio_wake) begin
          src_d   = SRC_GPIO;
          state_d = ST_WARM;
          cnt_d   = '0;
          pd_clr  = 1'b1;
        end
      end
      ST_WARM: begin
        if (cnt_q == CNT_FULL) begin
          state_d = ST_RUN;
          if (src_q == SRC_INT)  irq_d[idx_q] = 1'b1;
          if (src_q == SRC_GPIO) res_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_HOLD: begin
        if (int_rise[idx_q]) begin
          state_d      = ST_RUN;
          irq_d[idx_q] = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q     <= ST_RUN;
      src_q       <= SRC_INT;
      idx_q       <= 2'd0;
      cnt_q       <= '0;
      wake_irq    <= '0;
      wake_resume <= 1'b0;
    end else begin
      state_q     <= state_d;
      src_q       <= src_d;
      idx_q       <= idx_d;
      cnt_q       <= cnt_d;
      wake_irq    <= irq_d;
      wake_resume <= res_d;
    end
  end

  // R9: a running, non-idle block raises no wake report on the next cycle
  a_r9_quiet_when_running: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_RUN && !idl_bit) |=> (wake_irq == '0 && !wake_resume));

  // R6: at most one interrupt is reported per release
  a_r6_single_irq: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(wake_irq));

  // R7: a port-pin resume never comes with an interrupt request
  a_r7_resume_excl: assert property (@(posedge clk) disable iff (!por_n)
    wake_resume |-> (wake_irq == '0));

endmodule

// File: rtl/pwk_top.sv
module pwk_top
  import pwk_pkg::*;
#(
  parameter int WARM_W = 10,
  parameter int PORT_W = 8,
  parameter int XINT_W = 2,
  parameter int INT0_BIT = 2,
  parameter int INT1_BIT = 3,
  parameter logic [PORT_W-1:0] PA_WAKE_MASK = 8'hFF,
  parameter logic [PORT_W-1:0] PB_WAKE_MASK = 8'hBF
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_pin,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        ctl_q,
  input  logic              ext_release,
  input  logic [N_XINT-1:0] int_en,
  input  logic [XINT_W-1:0] xint_pin,
  input  logic [PORT_W-1:0] port_a,
  input  logic [PORT_W-1:0] port_b,
  input  logic [PORT_W-1:0] wake_en_a,
  input  logic [PORT_W-1:0] wake_en_b,
  output logic              osc_en,
  output logic              cpu_clk_en,
  output logic              core_rst,
  output logic [N_XINT-1:0] wake_irq,
  output logic              wake_resume
);
  localparam int SW = 1 + XINT_W + 2 * PORT_W;
  localparam logic [SW-1:0] SYNC_INIT = {1'b0, {(SW-1){1'b1}}};

  logic [SW-1:0] pin_now, pin_prev;
  logic [PORT_W-1:0] a_now, a_prev, b_now, b_prev, a_fall, b_fall;
  logic [XINT_W-1:0] x_now, x_prev;
  logic              rst_now, rst_prev, rst_rise;
  logic [N_XINT-1:0] ip_now, ip_prev, int_fall, int_rise;
  logic              gpio_wake, pd_clr, idl_clr, wr_ok;
  pwk_state_e        state;

  pwk_sync #(.W(SW), .INIT(SYNC_INIT)) u_sync (
    .clk(clk), .por_n(por_n),
    .d({rst_pin, xint_pin, port_b, port_a}),
    .now(pin_now), .prev(pin_prev)
  );

  assign {rst_now, x_now, b_now, a_now}     = pin_now;
  assign {rst_prev, x_prev, b_prev, a_prev} = pin_prev;

  assign rst_rise = rst_now & ~rst_prev;
  assign core_rst = rst_now;
  assign a_fall   = a_prev & ~a_now;
  assign b_fall   = b_prev & ~b_now;

  assign ip_now   = {x_now, b_now[INT1_BIT], b_now[INT0_BIT]};
  assign ip_prev  = {x_prev, b_prev[INT1_BIT], b_prev[INT0_BIT]};
  assign int_fall = ip_prev & ~ip_now & int_en;
  assign int_rise = ~ip_prev & ip_now;

  assign gpio_wake = (|(a_fall & wake_en_a & PA_WAKE_MASK)) |
                     (|(b_fall & wake_en_b & PB_WAKE_MASK));

  assign osc_en     = (state != ST_STOP);
  assign cpu_clk_en = (state == ST_RUN) && !ctl_q[IDL_BIT];
  assign wr_ok      = wr_en && cpu_clk_en;

  pwk_ctl_reg u_ctl (
    .clk(clk), .por_n(por_n), .soft_rst(rst_now), .wr_ok(wr_ok),
    .wr_data(wr_data), .pd_clr(pd_clr), .idl_clr(idl_clr), .ctl(ctl_q)
  );

  pwk_wake_fsm #(.WARM_W(WARM_W)) u_fsm (
    .clk(clk), .por_n(por_n), .pd_bit(ctl_q[PD_BIT]), .idl_bit(ctl_q[IDL_BIT]),
    .ext_release(ext_release), .rst_rise(rst_rise), .int_fall(int_fall),
    .int_rise(int_rise), .gpio_wake(gpio_wake), .state_q(state),
    .pd_clr(pd_clr), .idl_clr(idl_clr), .wake_irq(wake_irq),
    .wake_resume(wake_resume)
  );

  // R3: when the oscillator restarts, the stop bit has already been cleared
  a_r3_pd_cleared_on_wake: assert property (@(posedge clk) disable iff (!por_n)
    $rose(osc_en) |-> !ctl_q[PD_BIT]);

  // R2: a stop write shuts the oscillator one edge after the write lands
  a_r2_stop_follows_write: assert property (@(posedge clk) disable iff (!por_n)
    (wr_ok && wr_data[PD_BIT] && !rst_now) |=> ##1 !osc_en);

endmodule

// File: tb/test_pwk_top.sv
module test_pwk_top;
  localparam int WW = 4;
  localparam int WARM_LAT = 3 + (1 << WW);

  logic clk = 1'b0;
  logic por_n, rst_pin, wr_en, ext_release, osc_en, cpu_clk_en, core_rst, wake_resume;
  logic [7:0] wr_data, ctl_q, port_a, port_b, wake_en_a, wake_en_b;
  logic [3:0] int_en, wake_irq;
  logic [1:0] xint_pin;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pwk_top #(.WARM_W(WW)) i_pwk_top (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .wr_en(wr_en), .wr_data(wr_data),
    .ctl_q(ctl_q), .ext_release(ext_release), .int_en(int_en), .xint_pin(xint_pin),
    .port_a(port_a), .port_b(port_b), .wake_en_a(wake_en_a), .wake_en_b(wake_en_b),
    .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .core_rst(core_rst),
    .wake_irq(wake_irq), .wake_resume(wake_resume)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ctl(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic stop_now(input logic [7:0] keep);
    write_ctl(keep | 8'h02);
    settle(1);
  endtask

  task automatic wait_release(input int lim, output int n, output logic [3:0] irq,
                              output logic res);
    n = 0;
    irq = 4'h0;
    res = 1'b0;
    while (n < lim) begin
      @(negedge clk);
      n++;
      if (cpu_clk_en) begin
        irq = wake_irq;
        res = wake_resume;
        break;
      end
    end
  endtask

  task automatic reset_wake(input string tag);
    int n;
    logic [3:0] irq;
    logic res;
    rst_pin = 1'b1;
    wait_release(60, n, irq, res);
    check(tag, {n[15:0], 11'd0, irq, res}, {16'(WARM_LAT), 16'h0000});
    rst_pin = 1'b0;
    settle(5);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int n;
    logic [3:0] irq;
    logic res;
    por_n = 1'b0; rst_pin = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    ext_release = 1'b0; int_en = 4'h0; xint_pin = 2'b11;
    port_a = 8'hFF; port_b = 8'hFF; wake_en_a = 8'h00; wake_en_b = 8'h00;
    settle(3);
    por_n = 1'b1;
    settle(2);
    // R1 reset state
    check("R1 ctl", {24'd0, ctl_q}, 32'h10);
    check("R1 outputs", {osc_en, cpu_clk_en, core_rst, wake_irq, wake_resume},
          {1'b1, 1'b1, 1'b0, 4'h0, 1'b0});

    // R10 write and reset-level clear
    write_ctl(8'hEC);
    check("R10 write", {24'd0, ctl_q}, 32'hEC);
    rst_pin = 1'b1;
    settle(4);
    check("R10 clear pof0", {24'd0, ctl_q}, 32'h00);
    check("R5 core_rst high", {31'd0, core_rst}, 32'd1);
    rst_pin = 1'b0;
    settle(4);
    write_ctl(8'h1C);
    rst_pin = 1'b1;
    settle(4);
    check("R10 clear pof1", {24'd0, ctl_q}, 32'h10);
    rst_pin = 1'b0;
    settle(4);

    // R2 stop, R3 interrupt wake after warm-up
    int_en = 4'b0001;
    stop_now(8'h10);
    check("R2 stopped", {30'd0, osc_en, cpu_clk_en}, 32'd0);
    settle(12);
    check("R2 stays stopped", {30'd0, osc_en, cpu_clk_en}, 32'd0);
    port_b[2] = 1'b0;
    wait_release(60, n, irq, res);
    check("R3 latency", n, WARM_LAT);
    check("R3 irq", {27'd0, irq, res}, {27'd0, 4'b0001, 1'b0});
    check("R3 pd bit", {31'd0, ctl_q[1]}, 32'd0);
    port_b[2] = 1'b1;
    settle(5);

    // R4 external release on the rising edge
    ext_release = 1'b1;
    int_en = 4'b0010;
    stop_now(8'h10);
    port_b[3] = 1'b0;
    wait_release(30, n, irq, res);
    check("R4 held", {n[15:0], 14'd0, osc_en, cpu_clk_en}, {16'd30, 16'h0002});
    port_b[3] = 1'b1;
    wait_release(30, n, irq, res);
    check("R4 release", {n[15:0], 11'd0, irq, res}, {16'd3, 11'd0, 4'b0010, 1'b0});
    ext_release = 1'b0;
    settle(5);

    // R5 reset-pin wake
    stop_now(8'h10);
    rst_pin = 1'b1;
    wait_release(60, n, irq, res);
    check("R5 reset wake", {n[15:0], 11'd0, irq, res}, {16'(WARM_LAT), 16'h0000});
    check("R5 core_rst ctl", {23'd0, core_rst, ctl_q}, {23'd0, 1'b1, 8'h10});
    rst_pin = 1'b0;
    settle(5);
    check("R5 core_rst low", {31'd0, core_rst}, 32'd0);

    // R6/R7 sweep over every port pin, interrupts disabled
    int_en = 4'h0;
    for (int p = 0; p < 16; p++) begin
      logic wakes;
      wakes = (p != 14);
      wake_en_a = (p < 8) ? 8'(1 << p) : 8'h00;
      wake_en_b = (p >= 8) ? 8'(1 << (p - 8)) : 8'h00;
      stop_now(8'h10);
      if (p < 8) port_a[p] = 1'b0; else port_b[p - 8] = 1'b0;
      wait_release(40, n, irq, res);
      if (wakes) begin
        if (p == 10 || p == 11)
          check("R7 int pin via port enable", {n[15:0], 11'd0, irq, res},
                {16'(WARM_LAT), 11'd0, 4'h0, 1'b1});
        else
          check("R6 port wake", {n[15:0], 11'd0, irq, res},
                {16'(WARM_LAT), 11'd0, 4'h0, 1'b1});
      end else begin
        check("R6 port_b bit6 no wake", {n[15:0], 15'd0, osc_en}, {16'd40, 16'd0});
        reset_wake("R5 recovery");
      end
      port_a = 8'hFF;
      port_b = 8'hFF;
      settle(5);
    end

    // R7 interrupt and port enable together: interrupt wins
    wake_en_a = 8'h00;
    wake_en_b = 8'h0C;
    int_en = 4'b0001;
    stop_now(8'h10);
    port_b[2] = 1'b0;
    wait_release(40, n, irq, res);
    check("R7 both enabled", {n[15:0], 11'd0, irq, res}, {16'(WARM_LAT), 11'd0, 4'b0001, 1'b0});
    port_b[2] = 1'b1;
    settle(5);

    // R8 third/fourth interrupt pins need their enables
    wake_en_a = 8'hFF;
    wake_en_b = 8'hFF;
    int_en = 4'h0;
    stop_now(8'h10);
    xint_pin[0] = 1'b0;
    wait_release(40, n, irq, res);
    check("R8 disabled no wake", {n[15:0], 15'd0, osc_en}, {16'd40, 16'd0});
    reset_wake("R5 recovery");
    xint_pin = 2'b11;
    settle(5);
    for (int k = 0; k < 2; k++) begin
      int_en = 4'(1 << (k + 2));
      stop_now(8'h10);
      xint_pin[k] = 1'b0;
      wait_release(40, n, irq, res);
      check("R8 enabled wake", {n[15:0], 11'd0, irq, res},
            {16'(WARM_LAT), 11'd0, 4'(1 << (k + 2)), 1'b0});
      xint_pin = 2'b11;
      settle(5);
    end

    // R9 edges while running are ignored
    int_en = 4'hF;
    begin
      int seen;
      seen = 0;
      port_a = 8'h00; port_b = 8'h00; xint_pin = 2'b00;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (wake_irq != 4'h0 || wake_resume || !cpu_clk_en || !osc_en) seen++;
      end
      port_a = 8'hFF; port_b = 8'hFF; xint_pin = 2'b11;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (wake_irq != 4'h0 || wake_resume || !cpu_clk_en || !osc_en) seen++;
      end
      check("R9 running ignores edges", seen, 0);
    end
    wake_en_a = 8'h00;
    wake_en_b = 8'h00;

    // R11 idle gating and interrupt exit
    int_en = 4'b0001;
    write_ctl(8'h11);
    settle(1);
    check("R11 idle gate", {30'd0, osc_en, cpu_clk_en}, 32'd2);
    port_b[2] = 1'b0;
    wait_release(20, n, irq, res);
    check("R11 idle exit", {n[15:0], 11'd0, irq, res}, {16'd3, 11'd0, 4'b0001, 1'b0});
    check("R11 idle bit", {31'd0, ctl_q[0]}, 32'd0);
    port_b[2] = 1'b1;
    settle(5);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule